// File: doc/BRIEF.md
# Open-Drain Port Expander Serial Slave

This block is the two-wire serial slave front end of an eight-line open-drain port expander. It runs from a system clock that is much faster than the bus clock. It samples SCL and SDA through synchronizers and pulls SDA low through a single pull-down output. It finds START and STOP conditions, compares the first byte of each transfer with its own 7-bit address, and acknowledges the byte when the address matches.

In a write transfer, every data byte that follows is acknowledged and becomes the new open-drain output value at once. No register pointer is involved. In a read transfer, the slave returns the live port levels first, then a byte of transition flags, then the port levels again, and keeps alternating until the master declines a byte. A snapshot strobe goes to an external transition detector at the address acknowledge and at every master acknowledge that comes before a port byte. On the same strobe the block captures the port levels and the flag bits that it will send next.

An active-low abort input ends any transfer at once and leaves the slave idle, as it is after a STOP.

Top module: `pexp_i2c_slave`

## Requirements
- R1: The slave watches the bus only after a START, which is SDA falling while SCL is high. A STOP, which is SDA rising while SCL is high, returns it to idle. Bytes clocked without a preceding START are never acknowledged.
- R2: The first byte after START carries the address in bits 7..1, sent MSB first, and the direction in bit 0, where 1 means read. If bits 7..1 equal `dev_addr_i`, the slave pulls SDA low through the ninth clock. Otherwise it does not acknowledge, and it ignores the bus until the next START or STOP.
- R3: In a write, each data byte is acknowledged. The byte appears on `port_out_o` at the rising edge of its ninth clock, together with a one-cycle `port_wr_o` pulse. Any number of bytes may follow.
- R4: `snap_o` is a one-cycle pulse at the rising SCL edge of the address acknowledge, for both directions. It also pulses at each master acknowledge that precedes a port byte. It never pulses at the other acknowledges.
- R5: A read returns bytes in the order port levels, flags, port levels, flags, and so on. The flag byte equals `flags_i` as captured at the most recent `snap_o`.
- R6: Every port byte equals `port_lvl_i` as sampled at the acknowledge just before it. Level changes after that point show up in the next port byte.
- R7: After the master answers a read byte with a NACK, the slave releases SDA and drives nothing more until START or STOP.
- R8: A low `abort_n` releases SDA within one cycle and returns the slave to idle. It leaves `port_out_o` unchanged, and the next transfer works normally.
- R9: Data goes out MSB first. `sda_pd_o` changes only while the synchronized SCL is low.
- R10: After `arst_n`, SDA is released, `port_out_o` equals `OUT_INIT`, and no strobe is pending.
- R11: A repeated START in the middle of a transfer restarts the address phase, so a write can be followed directly by a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| arst_n | input | 1 | Asynchronous active-low block reset |
| abort_n | input | 1 | Active-low transfer abort |
| dev_addr_i | input | 7 | Own 7-bit bus address |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pd_o | output | 1 | 1 pulls SDA low |
| port_lvl_i | input | 8 | Present logic levels on the eight port pins |
| flags_i | input | 8 | Transition flags from the detector |
| snap_o | output | 1 | Snapshot/clear strobe to the detector |
| port_out_o | output | 8 | Open-drain output value (1 = released) |
| port_wr_o | output | 1 | Valid pulse when port_out_o is rewritten |

`port_wr_o` behaves as a valid signal with no ready. The output register always accepts a byte, so there is no back-pressure. A master paces itself only through the bus clock.

## Verification
Writes are tried with one byte and with several bytes, sent to the matching address and to other addresses. This separates acknowledged updates from ignored traffic. Reads of one, two and three bytes check the port/flag alternation. A port change injected during the flag byte distinguishes resampling at the master acknowledge from reuse of the first snapshot. Bytes clocked without a START, a repeated START from write into read, a NACK followed by release, and an abort while the slave holds SDA low each isolate one control path. Random transfers, with random addresses, directions, lengths and data, are checked against model functions.

// File: rtl/pexp_pkg.sv
package pexp_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_WAIT
  } pexp_state_e;
endpackage

// File: rtl/pexp_line_sync.sv
module pexp_line_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= {STAGES{INIT}};
    else         chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pexp_bus_cond.sv
module pexp_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw, synced;
  logic             scl_q, sda_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    pexp_line_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .d_i    (raw[g]),
      .q_o    (synced[g])
    );
  end

  assign scl_s = synced[0];
  assign sda_s = synced[1];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/pexp_i2c_slave.sv
module pexp_i2c_slave
  import pexp_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  OUT_INIT    = 8'hF0
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              abort_n,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pd_o,
  input  logic [BYTE_W-1:0] port_lvl_i,
  input  logic [BYTE_W-1:0] flags_i,
  output logic              snap_o,
  output logic [BYTE_W-1:0] port_out_o,
  output logic              port_wr_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;

  pexp_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk      (clk),
    .arst_n   (arst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p)
  );

  pexp_state_e       state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh, port_hold, flag_hold, out_q;
  logic              rd_dir, flag_next, pd_q, snap_q, wr_q;
  logic              addr_hit;
  logic [BYTE_W-1:0] next_tx;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  assign addr_hit = (rx_sh[BYTE_W-1:1] == dev_addr_i);
  assign next_tx  = flag_next ? flag_hold : port_hold;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      port_hold <= '0;
      flag_hold <= '0;
      out_q     <= OUT_INIT;
      rd_dir    <= 1'b0;
      flag_next <= 1'b0;
      pd_q      <= 1'b0;
      snap_q    <= 1'b0;
      wr_q      <= 1'b0;
    end else begin
      snap_q <= 1'b0;
      wr_q   <= 1'b0;
      if (!abort_n) begin
        state   <= ST_IDLE;
        pd_q    <= 1'b0;
        bit_cnt <= '0;
      end else if (start_p) begin
        state   <= ST_ADDR;
        pd_q    <= 1'b0;
        bit_cnt <= '0;
      end else if (stop_p) begin
        state   <= ST_IDLE;
        pd_q    <= 1'b0;
        bit_cnt <= '0;
      end else begin
        unique case (state)
          ST_IDLE, ST_WAIT: ;
          ST_ADDR: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == LAST) begin
              if (addr_hit) begin
                pd_q   <= 1'b1;
                rd_dir <= rx_sh[0];
                state  <= ST_ADDR_ACK;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_rise) begin
              snap_q    <= 1'b1;
              port_hold <= port_lvl_i;
              flag_hold <= flags_i;
            end else if (scl_fall) begin
              bit_cnt <= '0;
              if (rd_dir) begin
                state     <= ST_RD;
                tx_sh     <= port_hold;
                pd_q      <= ~port_hold[BYTE_W-1];
                flag_next <= 1'b1;
              end else begin
                state <= ST_WR;
                pd_q  <= 1'b0;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == LAST) begin
              pd_q  <= 1'b1;
              state <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (scl_rise) begin
              out_q <= rx_sh;
              wr_q  <= 1'b1;
            end else if (scl_fall) begin
              pd_q    <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (bit_cnt == LAST) begin
                pd_q  <= 1'b0;
                state <= ST_RD_ACK;
              end else begin
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                pd_q  <= ~tx_sh[BYTE_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              if (sda_s) begin
                state <= ST_WAIT;
              end else if (!flag_next) begin
                snap_q    <= 1'b1;
                port_hold <= port_lvl_i;
                flag_hold <= flags_i;
              end
            end else if (scl_fall) begin
              bit_cnt   <= '0;
              state     <= ST_RD;
              tx_sh     <= next_tx;
              pd_q      <= ~next_tx[BYTE_W-1];
              flag_next <= ~flag_next;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_pd_o   = pd_q;
  assign snap_o     = snap_q;
  assign port_out_o = out_q;
  assign port_wr_o  = wr_q;
endmodule

// File: rtl/pexp_i2c_slave_chk.sv
module pexp_i2c_slave_chk (
  input logic       clk,
  input logic       arst_n,
  input logic       abort_n,
  input logic       scl_s,
  input logic       sda_pd_o,
  input logic       snap_o,
  input logic       port_wr_o,
  input logic [7:0] port_out_o
);
  // R4: the strobe lasts one cycle and falls in the high phase of an acknowledge clock
  p_snap_pulse_r4: assert property (@(posedge clk) disable iff (!arst_n)
    snap_o |=> !snap_o);
  p_snap_scl_high_r4: assert property (@(posedge clk) disable iff (!arst_n)
    snap_o |-> scl_s);

  // R8: abort releases the data line on the next cycle
  p_abort_release_r8: assert property (@(posedge clk) disable iff (!arst_n)
    !abort_n |=> !sda_pd_o);

  // R9: the pull-down moves only while the clock is low
  p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (abort_n && $past(abort_n) && !$stable(sda_pd_o)) |-> !scl_s);

  // R3: the output value changes only together with its valid pulse
  p_out_with_valid_r3: assert property (@(posedge clk) disable iff (!arst_n)
    !$stable(port_out_o) |-> port_wr_o);
  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!arst_n)
    port_wr_o |=> !port_wr_o);
endmodule

bind pexp_i2c_slave pexp_i2c_slave_chk u_chk (
  .clk        (clk),
  .arst_n     (arst_n),
  .abort_n    (abort_n),
  .scl_s      (scl_s),
  .sda_pd_o   (sda_pd_o),
  .snap_o     (snap_o),
  .port_wr_o  (port_wr_o),
  .port_out_o (port_out_o)
);

// File: tb/pexp_i2c_slave_test.sv
module pexp_i2c_slave_test;
  localparam int         Q    = 8;
  localparam logic [6:0] DEV  = 7'h5A;
  localparam logic [7:0] INIT = 8'hF0;

  logic       clk = 1'b0;
  logic       arst_n = 1'b0, abort_n = 1'b1;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [7:0] port_lvl = 8'h00, flags = 8'h00;
  logic       sda_pd, snap, port_wr;
  logic [7:0] port_out;
  wire        sda_line = sda_m & ~sda_pd;

  int checks = 0, errors = 0, snaps = 0;

  always #4 clk = ~clk;

  pexp_i2c_slave #(.SYNC_STAGES(2), .OUT_INIT(INIT)) uut (
    .clk(clk), .arst_n(arst_n), .abort_n(abort_n), .dev_addr_i(DEV),
    .scl_i(scl_m), .sda_i(sda_line), .sda_pd_o(sda_pd),
    .port_lvl_i(port_lvl), .flags_i(flags), .snap_o(snap),
    .port_out_o(port_out), .port_wr_o(port_wr)
  );

  always @(posedge clk) if (snap) snaps++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
    end
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); acked = ~sda_line; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); scl_m = 1'b1; w(Q); b[i] = sda_line; w(Q); scl_m = 1'b0;
    end
    w(1); sda_m = ~give_ack; w(Q-1); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(2); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] exp_rd(input int idx, input logic [7:0] p, input logic [7:0] f);
    return (idx % 2 == 0) ? p : f;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic       a;
    logic [7:0] b, exp_out;
    int         s0;
    void'($urandom(32'd1234));
    w(5); arst_n = 1'b1; w(5);

    // R10 reset state
    chk("R10 sda", sda_pd, 0);
    chk("R10 out", port_out, INIT);
    chk("R10 snap", snaps, 0);

    // R1 no START: clocked address byte is ignored
    scl_m = 1'b0; w(Q);
    wr_byte({DEV, 1'b0}, a);
    chk("R1 no-start ack", a, 0);
    bus_stop();

    // R2 R3 R4 two-byte write
    s0 = snaps;
    bus_start(); wr_byte({DEV, 1'b0}, a); chk("R2 addr ack", a, 1);
    wr_byte(8'hA5, a); chk("R3 ack1", a, 1); chk("R3 out1", port_out, 8'hA5);
    wr_byte(8'h3C, a); chk("R3 ack2", a, 1); chk("R3 out2", port_out, 8'h3C);
    bus_stop();
    chk("R4 write snaps", snaps - s0, 1);
    chk("R1 idle release", sda_pd, 0);

    // R2 other address ignored
    bus_start(); wr_byte({DEV ^ 7'h11, 1'b0}, a); chk("R2 miss ack", a, 0);
    wr_byte(8'h00, a); chk("R2 miss data ack", a, 0);
    bus_stop(); chk("R2 miss out", port_out, 8'h3C);

    // R5 R6 R7 R9 three-byte read with a change during the flag byte
    port_lvl = 8'h96; flags = 8'h41; s0 = snaps;
    bus_start(); wr_byte({DEV, 1'b1}, a); chk("R2 rd ack", a, 1);
    rd_byte(1'b1, b); chk("R6 R9 port0", b, 8'h96);
    port_lvl = 8'h2B; flags = 8'h0F;
    rd_byte(1'b1, b); chk("R5 flags", b, 8'h41);
    rd_byte(1'b0, b); chk("R6 resample", b, 8'h2B);
    w(Q); chk("R7 release after nack", sda_pd, 0);
    bus_stop();
    chk("R4 read snaps", snaps - s0, 2);

    // R11 repeated START from write into read
    port_lvl = 8'hC3;
    bus_start(); wr_byte({DEV, 1'b0}, a); wr_byte(8'h11, a);
    bus_start(); wr_byte({DEV, 1'b1}, a); chk("R11 rd ack", a, 1);
    rd_byte(1'b0, b); chk("R11 rd data", b, 8'hC3);
    bus_stop(); chk("R11 out", port_out, 8'h11);

    // R8 abort while the slave holds SDA low
    port_lvl = 8'h00;
    bus_start(); wr_byte({DEV, 1'b1}, a); w(Q);
    chk("R9 msb drive", sda_pd, 1);
    abort_n = 1'b0; w(3); abort_n = 1'b1; w(2);
    chk("R8 release", sda_pd, 0);
    chk("R8 out kept", port_out, 8'h11);
    bus_stop();
    bus_start(); wr_byte({DEV, 1'b0}, a); wr_byte(8'h77, a); bus_stop();
    chk("R8 after abort", port_out, 8'h77);

    // random transfers
    exp_out = 8'h77;
    for (int t = 0; t < 30; t++) begin
      logic       hit, rd;
      int         n;
      logic [6:0] ad;
      hit = $urandom % 2; rd = $urandom % 2; n = 1 + $urandom % 3;
      ad  = hit ? DEV : (DEV ^ 7'(1 + $urandom % 127));
      port_lvl = 8'($urandom); flags = 8'($urandom);
      bus_start(); wr_byte({ad, rd}, a);
      chk("R2 rand ack", a, hit);
      if (hit && rd) begin
        for (int k = 0; k < n; k++) begin
          rd_byte(k != n - 1, b);
          chk("R5 rand rd", b, exp_rd(k, port_lvl, flags));
        end
      end else if (!rd) begin
        for (int k = 0; k < n; k++) begin
          b = 8'($urandom); wr_byte(b, a);
          chk("R3 rand wr ack", a, hit);
          if (hit) exp_out = b;
        end
      end
      bus_stop();
      chk("R3 rand out", port_out, exp_out);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule